// File: doc/BRIEF.md
# Inverted-Polarity PWM Timer Channel

This block is a single pulse-width timer channel controlled through four 32-bit registers on a small memory-mapped port. A free-running counter advances once per clock while the channel is enabled. Two compare registers set the waveform. The duty register sets how many cycles at the start of each period the output is held low. The period register sets the cycle length, and the counter returns to zero when a period ends. The output is active low: it is low for the duty portion and high for the rest of the period.

Software can rewrite either compare register at any time. The new value applies from the next cycle and the counter keeps running, so the period in which the change lands may mix old and new settings. The period end can raise a sticky interrupt flag, and it can also stop the channel in one-shot operation. Clearing the enable bit or the output-enable bit drives the output low on the next clock.

Top module: `pwm_timer_chan`

## Requirements
- R1: The port takes a byte address. Word 0x0 is the counter, 0x4 is the duty compare, 0x8 is the period compare and 0xC is the control register. An address with bits [1:0] not zero is ignored on write and reads zero. Values written to the duty and period registers read back unchanged.
- R2: The control bits are: bit0 enable, bit1 clock-source select, bit2 edge select, bit3 output enable, bit4 one-shot, bit5 interrupt enable, bit6 interrupt flag and bit7 counter clear. Bit8 is a capture select. Bits 1, 2 and 8 are stored and read back but have no other effect. Bits 31:9 and bit7 always read as zero.
- R3: After reset, every register reads zero and both `pwm_o` and `irq_o` are low.
- R4: While enabled, the counter goes up by one each clock. In a cycle where counter+1 is at least the period value, the counter returns to 0 instead. A period value of P therefore gives the count sequence 0..P-1.
- R5: While enable and output enable are both set, `pwm_o` is low when the counter is below the duty value and high when it is at or above it. A duty value of 0 keeps the output high all the time. A duty value at or above the period keeps it low all the time.
- R6: A control write that clears enable or output enable makes `pwm_o` low from the next clock. While enable is clear, the counter holds its value.
- R7: A write to either compare register takes effect from the next cycle and does not clear the counter.
- R8: At each period wrap with interrupt enable set, the flag (bit6) sets. `irq_o` equals the flag ANDed with interrupt enable. Writing 1 to bit6 clears the flag and writing 0 leaves it unchanged. If a clear and a wrap fall in the same cycle, the flag ends up set.
- R9: With one-shot set, the first period wrap clears the enable bit. The counter is left at 0 and the output low.
- R10: A control write with bit7 set clears the counter in that cycle. A write to word 0x0 loads the counter. Either write takes the place of the increment and of any wrap in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| pwm_o | output | 1 | Registered PWM output, active low |
| irq_o | output | 1 | Interrupt request |

## Verification
The period wrap and a software write to the interrupt flag can land on the same clock edge. Both change the flag, and the flag must end up set. The bench provokes this by polling the counter at falling edges. When the counter reads period-1, it drives a write-one-to-clear control write at once, so the write lands on the same rising edge as the wrap. It then expects the flag to read back as 1 and `irq_o` to be high. A second clear, placed away from the wrap, must then drop both.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    typedef enum logic [1:0] {
        WSEL_COUNT  = 2'd0,
        WSEL_DUTY   = 2'd1,
        WSEL_PERIOD = 2'd2,
        WSEL_CTRL   = 2'd3
    } word_sel_e;

    // control word, bit 0 at the bottom
    typedef struct packed {
        logic capt_sel;
        logic cnt_clr;
        logic irq_flag;
        logic irq_en;
        logic one_shot;
        logic out_en;
        logic edge_sel;
        logic src_sel;
        logic run_en;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_timer_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] cnt_q_i,
    input  logic          wrap_i,
    output logic [DW-1:0] rdata_o,
    output ctrl_t         ctrl_q_o,
    output ctrl_t         ctrl_d_o,
    output logic [DW-1:0] duty_d_o,
    output logic [DW-1:0] period_q_o,
    output logic          cnt_load_o,
    output logic          cnt_clr_o
);

    typedef struct packed {
        ctrl_t         ctrl;
        logic [DW-1:0] duty;
        logic [DW-1:0] period;
    } regs_t;

    regs_t     regs_d, regs_q;
    logic      aligned;
    logic      hit;
    word_sel_e wsel;
    ctrl_t     wr_ctrl;

    always_comb begin
        aligned = (addr_i[1:0] == 2'b00);
        wsel    = word_sel_e'(addr_i[3:2]);
        hit     = wr_en_i && aligned;
        wr_ctrl = ctrl_t'(wdata_i[CTRL_W-1:0]);
        regs_d  = regs_q;

        cnt_load_o = hit && (wsel == WSEL_COUNT);
        cnt_clr_o  = hit && (wsel == WSEL_CTRL) && wr_ctrl.cnt_clr;

        if (hit) begin
            case (wsel)
                WSEL_DUTY:   regs_d.duty   = wdata_i;
                WSEL_PERIOD: regs_d.period = wdata_i;
                WSEL_CTRL: begin
                    regs_d.ctrl          = wr_ctrl;
                    regs_d.ctrl.cnt_clr  = 1'b0;
                    regs_d.ctrl.irq_flag = regs_q.ctrl.irq_flag & ~wr_ctrl.irq_flag;
                end
                default: ;
            endcase
        end

        // period-end events take priority over the software write
        if (wrap_i && regs_q.ctrl.irq_en) begin
            regs_d.ctrl.irq_flag = 1'b1;
        end
        if (wrap_i && regs_q.ctrl.one_shot) begin
            regs_d.ctrl.run_en = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (aligned) begin
            case (wsel)
                WSEL_COUNT:  rdata_o = cnt_q_i;
                WSEL_DUTY:   rdata_o = regs_q.duty;
                WSEL_PERIOD: rdata_o = regs_q.period;
                default:     rdata_o = DW'(regs_q.ctrl);
            endcase
        end
    end

    assign ctrl_q_o   = regs_q.ctrl;
    assign ctrl_d_o   = regs_d.ctrl;
    assign duty_d_o   = regs_d.duty;
    assign period_q_o = regs_q.period;

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int unsigned DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          run_i,
    input  logic          load_i,
    input  logic [DW-1:0] load_val_i,
    input  logic          clr_i,
    input  logic [DW-1:0] period_i,
    output logic [DW-1:0] cnt_q_o,
    output logic [DW-1:0] cnt_d_o,
    output logic          wrap_o
);

    logic [DW-1:0] cnt_d, cnt_q;
    logic [DW:0]   cnt_inc;

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + {{DW{1'b0}}, 1'b1};
        wrap_o  = run_i && !load_i && !clr_i && (cnt_inc >= {1'b0, period_i});
        cnt_d   = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (load_i) begin
            cnt_d = load_val_i;
        end else if (wrap_o) begin
            cnt_d = '0;
        end else if (run_i) begin
            cnt_d = cnt_inc[DW-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_q_o = cnt_q;
    assign cnt_d_o = cnt_d;

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
    parameter int unsigned DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          run_d_i,
    input  logic          oe_d_i,
    input  logic [DW-1:0] cnt_d_i,
    input  logic [DW-1:0] duty_d_i,
    output logic          pwm_o
);

    logic pwm_d, pwm_q;

    // active-low duty phase: high only once the count has passed the duty point
    always_comb begin
        pwm_d = run_d_i && oe_d_i && (cnt_d_i >= duty_d_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pwm_q <= 1'b0;
        end else begin
            pwm_q <= pwm_d;
        end
    end

    assign pwm_o = pwm_q;

endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
    import pwm_timer_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          pwm_o,
    output logic          irq_o
);

    ctrl_t         ctrl_q;
    ctrl_t         ctrl_d;
    logic [DW-1:0] duty_d;
    logic [DW-1:0] period_q;
    logic [DW-1:0] cnt_q;
    logic [DW-1:0] cnt_d;
    logic          cnt_load;
    logic          cnt_clr;
    logic          wrap;

    pwm_regfile #(.DW(DW), .AW(AW)) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .cnt_q_i    (cnt_q),
        .wrap_i     (wrap),
        .rdata_o    (rdata_o),
        .ctrl_q_o   (ctrl_q),
        .ctrl_d_o   (ctrl_d),
        .duty_d_o   (duty_d),
        .period_q_o (period_q),
        .cnt_load_o (cnt_load),
        .cnt_clr_o  (cnt_clr)
    );

    pwm_counter #(.DW(DW)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (ctrl_q.run_en),
        .load_i     (cnt_load),
        .load_val_i (wdata_i),
        .clr_i      (cnt_clr),
        .period_i   (period_q),
        .cnt_q_o    (cnt_q),
        .cnt_d_o    (cnt_d),
        .wrap_o     (wrap)
    );

    pwm_out_stage #(.DW(DW)) u_out (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_d_i  (ctrl_d.run_en),
        .oe_d_i   (ctrl_d.out_en),
        .cnt_d_i  (cnt_d),
        .duty_d_i (duty_d),
        .pwm_o    (pwm_o)
    );

    assign irq_o = ctrl_q.irq_flag & ctrl_q.irq_en;

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 4
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          wr_en_i,
    input logic [AW-1:0] addr_i,
    input logic [DW-1:0] wdata_i,
    input logic          pwm_i,
    input logic          run_q_i,
    input logic          oe_q_i,
    input logic          irq_en_q_i,
    input logic          flag_q_i,
    input logic          one_shot_q_i,
    input logic          wrap_i,
    input logic [DW-1:0] cnt_q_i
);

    logic ctrl_wr;
    assign ctrl_wr = wr_en_i && (addr_i == AW'(12));

    AST_OUT_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwm_i |-> (run_q_i && oe_q_i)); // R6

    AST_DISABLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_wr && (!wdata_i[0] || !wdata_i[3])) |=> !pwm_i); // R6

    AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_i |=> (cnt_q_i == '0)); // R4

    AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrap_i && irq_en_q_i) |=> flag_q_i); // R8

    AST_ONE_SHOT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrap_i && one_shot_q_i) |=> (!run_q_i && !pwm_i)); // R9

    AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_wr && wdata_i[7]) |=> (cnt_q_i == '0)); // R10

endmodule

bind pwm_timer_chan pwm_timer_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .pwm_i        (pwm_o),
    .run_q_i      (ctrl_q.run_en),
    .oe_q_i       (ctrl_q.out_en),
    .irq_en_q_i   (ctrl_q.irq_en),
    .flag_q_i     (ctrl_q.irq_flag),
    .one_shot_q_i (ctrl_q.one_shot),
    .wrap_i       (wrap),
    .cnt_q_i      (cnt_q)
);

// File: tb/test_pwm_timer_chan.sv
module test_pwm_timer_chan;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  addr_i = 4'h0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        pwm_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    pwm_timer_chan i_pwm_timer_chan (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .pwm_o   (pwm_o),
        .irq_o   (irq_o)
    );

    always #10 clk_i = ~clk_i;

    // {address, write data, expected read-back}
    localparam logic [95:0] VEC [6] = '{
        {32'h4, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R1 duty
        {32'h8, 32'h1234_5678, 32'h1234_5678},  // R1 period
        {32'hC, 32'h0000_0106, 32'h0000_0106},  // R2 inert bits 1,2,8
        {32'hC, 32'hFFFF_FE06, 32'h0000_0006},  // R2 high bits and bit7 read 0
        {32'h0, 32'h0000_0055, 32'h0000_0055},  // R10 counter load
        {32'h1, 32'hFFFF_FFFF, 32'h0000_0000}   // R1 unaligned ignored
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_now(input logic [3:0] a, input logic [31:0] d);
        wr_en_i = 1'b1;
        addr_i  = a;
        wdata_i = d;
        @(negedge clk_i);
        wr_en_i = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk_i);
        wr_now(a, d);
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr_i = a;
        #1;
        d = rdata_o;
    endtask

    task automatic wait_cnt(input logic [31:0] v);
        logic [31:0] c;
        for (int i = 0; i < 40; i++) begin
            rd(4'h0, c);
            if (c == v) return;
            @(negedge clk_i);
        end
        check("wait_cnt", c, v);
    endtask

    initial begin
        repeat (50000) @(posedge clk_i);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] r2;
        logic [31:0] exp_cnt;
        logic        bad;

        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;

        // R3 reset state
        for (int a = 0; a < 4; a++) begin
            rd(4'(a * 4), r);
            check("R3 reg", r, 32'h0);
        end
        check("R3 pwm", {31'b0, pwm_o}, 32'h0);
        check("R3 irq", {31'b0, irq_o}, 32'h0);

        // R1/R2 vector table
        for (int i = 0; i < 6; i++) begin
            wr(VEC[i][67:64], VEC[i][63:32]);
            rd(VEC[i][67:64], r);
            check("R1/R2 readback", r, VEC[i][31:0]);
            check("R2 pwm idle", {31'b0, pwm_o}, 32'h0);
        end
        @(negedge clk_i);
        rd(4'h0, r);
        check("R2 counter held", r, 32'h55);

        // R4/R5 period 5, duty 2
        wr(4'h8, 32'd5);
        wr(4'h4, 32'd2);
        wr(4'h0, 32'd0);
        wr(4'hC, 32'h9);
        exp_cnt = 0;
        for (int i = 0; i < 12; i++) begin
            rd(4'h0, r);
            check("R4 count", r, exp_cnt);
            check("R5 level", {31'b0, pwm_o}, {31'b0, (exp_cnt >= 2)});
            @(negedge clk_i);
            exp_cnt = (exp_cnt + 1) % 5;
        end

        // R7 period rewrite does not restart the count
        wait_cnt(32'd3);
        wr_now(4'h8, 32'd100);
        rd(4'h0, r);
        check("R7 no restart", r, 32'd4);
        @(negedge clk_i);
        rd(4'h0, r);
        check("R7 new period", r, 32'd5);
        wr_now(4'h4, 32'd9);
        check("R7 duty immediate", {31'b0, pwm_o}, 32'h0);

        // R5 duty equal to period: always low; duty 0: always high
        wr(4'h8, 32'd4);
        wr(4'h4, 32'd4);
        bad = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk_i);
            if (pwm_o) bad = 1'b1;
        end
        check("R5 duty>=period low", {31'b0, bad}, 32'h0);
        wr(4'h4, 32'd0);
        bad = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (!pwm_o) bad = 1'b1;
            @(negedge clk_i);
        end
        check("R5 duty zero high", {31'b0, bad}, 32'h0);

        // R6 disable forces low and holds counter
        wr(4'hC, 32'h8);
        check("R6 en clear low", {31'b0, pwm_o}, 32'h0);
        rd(4'h0, r);
        @(negedge clk_i);
        @(negedge clk_i);
        rd(4'h0, r2);
        check("R6 counter hold", r2, r);
        wr(4'hC, 32'h9);
        check("R6 re-enabled high", {31'b0, pwm_o}, 32'h1);
        wr(4'hC, 32'h1);
        check("R6 oe clear low", {31'b0, pwm_o}, 32'h0);

        // R10 counter clear bit
        wr(4'h0, 32'd2);
        wr(4'hC, 32'h89);
        rd(4'h0, r);
        check("R10 clear", r, 32'h0);
        rd(4'hC, r);
        check("R10 bit7 reads 0", r, 32'h9);

        // R8 interrupt, period 5
        wr(4'h8, 32'd5);
        wr(4'h4, 32'd2);
        wr(4'hC, 32'h29);
        wait_cnt(32'd1);
        wr_now(4'hC, 32'h69);
        check("R8 cleared", {31'b0, irq_o}, 32'h0);
        wait_cnt(32'd4);
        check("R8 no early set", {31'b0, irq_o}, 32'h0);
        wr_now(4'hC, 32'h69);  // clear lands on the wrap edge
        check("R8 set wins irq", {31'b0, irq_o}, 32'h1);
        rd(4'hC, r);
        check("R8 set wins flag", r, 32'h69);
        wait_cnt(32'd2);
        wr_now(4'hC, 32'h29);
        check("R8 write 0 keeps", {31'b0, irq_o}, 32'h1);
        wait_cnt(32'd1);
        wr_now(4'hC, 32'h69);
        check("R8 w1c irq", {31'b0, irq_o}, 32'h0);
        rd(4'hC, r);
        check("R8 w1c flag", r, 32'h29);
        wr(4'hC, 32'h09);
        repeat (7) @(negedge clk_i);
        rd(4'hC, r);
        check("R8 disabled no flag", r, 32'h09);
        check("R8 disabled no irq", {31'b0, irq_o}, 32'h0);

        // R9 one-shot
        wr(4'h8, 32'd3);
        wr(4'h4, 32'd1);
        wr(4'h0, 32'd0);
        wr(4'hC, 32'h19);
        repeat (6) @(negedge clk_i);
        rd(4'hC, r);
        check("R9 enable cleared", r, 32'h18);
        rd(4'h0, r);
        check("R9 counter zero", r, 32'h0);
        check("R9 output low", {31'b0, pwm_o}, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule